// File: doc/BRIEF.md
# Offset-Binary Distributed-Arithmetic FIR Filter

This block is a four-tap FIR filter with fixed coefficients that has no hardware multiplier. Each accepted signed sample enters a tap delay line. The block then walks the tap bits one bit position per clock. On each clock, one bit from every tap forms an address into small precomputed tables of partial coefficient sums. The table outputs are registered and then folded into a carry-save accumulator. A single carry-propagate add at the end resolves the accumulator and applies a constant correction. One filtered sample leaves the block with a one-cycle valid strobe.

The tables use offset binary coding. Each tap bit counts as +1 or -1 instead of 1 or 0, which makes the table antisymmetric. Any address whose top bit is set is served by inverting the remaining address bits and negating the stored word. As a result, each partition stores only half of its entries. The taps are split into partitions, and each partition has its own half-size table and its own output register. The number of stored words therefore grows with the partition size and not with the total tap count.

A sample is accepted only while the block is idle. Samples offered at other times are dropped. Processing a sample takes one clock per sample bit plus a fixed drain.

Top module: `da_obc_fir`

## Requirements
- R1: While rst_ni is low, and after it is released, out_valid_o is 0, result_o is 0 and every tap holds 0. A reset in the middle of a sample cancels that sample: no pulse appears for it, and the next output is computed as if only the samples accepted after the reset exist.
- R2: Each output equals y[n] = h0·x[n] + h1·x[n-1] + h2·x[n-2] + h3·x[n-3]. Here x[n] is the latest accepted sample, x[n-k] is the k-th earlier accepted sample, and the default coefficients are h0=7, h1=-45, h2=127, h3=-128. Samples are 8-bit two's complement and the result is an exact 18-bit two's complement value.
- R3: If a sample is accepted on clock edge E0, out_valid_o is high for exactly the one cycle that follows edge E10. Every accepted sample produces exactly one pulse.
- R4: A sample is accepted only on an edge where in_valid_i is high and the block is idle. The block is idle after reset and from the cycle in which out_valid_o is high onward. If in_valid_i is high on any of edges E1 to E10 after an accept, it has no effect on the tap line or on any output.
- R5: If in_valid_i is held high continuously, one sample is accepted every 11 cycles. The sample taken is the one present on each accepting edge.
- R6: Extreme inputs (-128 and 127 in any mix) give exact results with no wrap-around.
- R7: result_o keeps the value of the last pulse until the next pulse.
- R8: A single sample of value 1 followed by zeros produces the outputs h0, h1, h2, h3 and then 0, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample offered this cycle |
| sample_i | input | 8 | Signed input sample |
| out_valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | 18 | Signed filtered result |

## Verification
A wrong table word, a mis-folded mirror address or a lost carry-save carry changes the value in result_o on the very next pulse, ten cycles after the accept edge. A corrupted tap then keeps producing errors in the following three results as that sample moves down the line. Errors in the bit counter or in the pipeline flags show up as a pulse in the wrong cycle, a double pulse or a missing pulse, or as a sample that is accepted while the block is busy. Each of these is visible within one sample period of 11 cycles.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } slot_t;

  localparam int unsigned DEF_TAPS   = 4;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_COEF_W = 8;

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
  parameter int unsigned TAPS   = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic [TAPS-1:0]   slice_o
);

  logic [DATA_W-1:0] taps_q [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     taps_q[k] <= '0;
        else if (load_i) taps_q[k] <= sample_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     taps_q[k] <= '0;
        else if (load_i) taps_q[k] <= taps_q[k-1];
      end
    end
    assign slice_o[k] = taps_q[k][bit_i];
  end

endmodule

// File: rtl/da_obc_part.sv
module da_obc_part #(
  parameter int unsigned TPP    = 2,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned T_W    = 11,
  parameter logic [TPP*COEF_W-1:0] PCOEF = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic                  neg_i,
  input  logic [TPP-1:0]        bits_i,
  output logic signed [T_W-1:0] part_o
);

  localparam int unsigned IDX_W   = TPP - 1;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  // stored half: top address bit is 0, every bit counts as +1 or -1
  function automatic logic signed [T_W-1:0] obc_entry(input int unsigned e);
    logic signed [T_W-1:0] acc;
    logic signed [T_W-1:0] h;
    acc = '0;
    for (int unsigned j = 0; j < TPP; j++) begin
      h = T_W'(signed'(PCOEF[j*COEF_W +: COEF_W]));
      if (j == TPP - 1 || ((e >> j) & 1) == 0) acc = acc - h;
      else                                      acc = acc + h;
    end
    return acc;
  endfunction

  function automatic logic signed [T_W-1:0] part_sum();
    logic signed [T_W-1:0] acc;
    acc = '0;
    for (int unsigned j = 0; j < TPP; j++)
      acc = acc + T_W'(signed'(PCOEF[j*COEF_W +: COEF_W]));
    return acc;
  endfunction

  localparam logic signed [T_W-1:0] PSUM = part_sum();

  logic signed [T_W-1:0] rom [ENTRIES];
  for (genvar e = 0; e < ENTRIES; e++) begin : g_rom
    assign rom[e] = obc_entry(e);
  end

  logic                  msb;
  logic [IDX_W-1:0]      idx;
  logic signed [T_W-1:0] raw;
  logic signed [T_W-1:0] val;

  always_comb begin
    msb = bits_i[TPP-1];
    idx = msb ? ~bits_i[IDX_W-1:0] : bits_i[IDX_W-1:0];
    raw = rom[idx];
    // mirror fold and sign-bit weight both flip the sign
    val = (msb ^ neg_i) ? -raw : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    part_o <= '0;
    else if (vld_i) part_o <= val;
  end

  assert_obc_fold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && ((&bits_i && !neg_i) || (bits_i == '0 && neg_i))) |=> (part_o == PSUM));

endmodule

// File: rtl/da_csa_acc.sv
module da_csa_acc #(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned T_W   = 11,
  parameter int unsigned PARTS = 2,
  parameter int unsigned BITS  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic                   first_i,
  input  logic                   last_i,
  input  logic [PARTS*T_W-1:0]   parts_i,
  output logic [ACC_W-1:0]       sum_o,
  output logic [ACC_W-1:0]       carry_o,
  output logic                   done_o
);

  localparam int unsigned CNT_W = $clog2(BITS + 1);

  logic [ACC_W-1:0] s_n, c_n, ext, maj;

  // MSB first: doubling a carry-save pair is exact
  always_comb begin
    s_n = first_i ? '0 : {sum_o[ACC_W-2:0], 1'b0};
    c_n = first_i ? '0 : {carry_o[ACC_W-2:0], 1'b0};
    ext = '0;
    maj = '0;
    for (int unsigned p = 0; p < PARTS; p++) begin
      ext = ACC_W'(signed'(parts_i[p*T_W +: T_W]));
      maj = (s_n & c_n) | (s_n & ext) | (c_n & ext);
      s_n = s_n ^ c_n ^ ext;
      c_n = {maj[ACC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      carry_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (vld_i) begin
        sum_o   <= s_n;
        carry_o <= c_n;
      end
      done_o <= vld_i & last_i;
    end
  end

  logic [CNT_W-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= '0;
    else if (vld_i) seen_q <= first_i ? CNT_W'(1) : seen_q + 1'b1;
  end

  assert_bit_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && last_i && !first_i) |-> ((seen_q + 1'b1) == CNT_W'(BITS)));

  assert_first_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> !(first_i && last_i));

endmodule

// File: rtl/da_obc_fir.sv
module da_obc_fir
  import fir_da_pkg::*;
#(
  parameter int unsigned TAPS   = DEF_TAPS,
  parameter int unsigned PARTS  = 2,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned COEF_W = DEF_COEF_W,
  parameter int unsigned OUT_W  = 18,
  parameter logic [TAPS*COEF_W-1:0] COEFS = 32'h807F_D307
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  result_o
);

  localparam int unsigned TPP   = TAPS / PARTS;
  localparam int unsigned T_W   = COEF_W + $clog2(TAPS) + 1;
  localparam int unsigned ACC_W = OUT_W + 2;
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned LAT   = DATA_W + 2;
  localparam int unsigned LC_W  = $clog2(LAT + 1);

  function automatic logic signed [ACC_W-1:0] coef_sum();
    logic signed [ACC_W-1:0] acc;
    acc = '0;
    for (int unsigned k = 0; k < TAPS; k++)
      acc = acc + ACC_W'(signed'(COEFS[k*COEF_W +: COEF_W]));
    return acc;
  endfunction

  localparam logic signed [ACC_W-1:0] CORR = -coef_sum();

  logic                   run_q;
  logic [BIT_W-1:0]       bit_q;
  slot_t                  s1_q;
  logic                   acc_done;
  logic                   idle;
  logic                   accept;
  logic                   sign_cyc;
  logic [TAPS-1:0]        slice;
  logic [PARTS*T_W-1:0]   parts_flat;
  logic [ACC_W-1:0]       acc_s, acc_c, full_sum;

  assign idle     = !run_q && !s1_q.vld && !acc_done;
  assign accept   = in_valid_i && idle;
  assign sign_cyc = run_q && (bit_q == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      bit_q <= '0;
    end else if (accept) begin
      run_q <= 1'b1;
      bit_q <= BIT_W'(DATA_W - 1);
    end else if (run_q) begin
      if (bit_q == '0) run_q <= 1'b0;
      else             bit_q <= bit_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else         s1_q <= '{vld: run_q, first: sign_cyc, last: run_q && (bit_q == '0)};
  end

  da_tap_line #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W)
  ) u_taps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .sample_i (sample_i),
    .bit_i    (bit_q),
    .slice_o  (slice)
  );

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    da_obc_part #(
      .TPP    (TPP),
      .COEF_W (COEF_W),
      .T_W    (T_W),
      .PCOEF  (COEFS[p*TPP*COEF_W +: TPP*COEF_W])
    ) u_part (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (run_q),
      .neg_i  (sign_cyc),
      .bits_i (slice[p*TPP +: TPP]),
      .part_o (parts_flat[p*T_W +: T_W])
    );
  end

  da_csa_acc #(
    .ACC_W (ACC_W),
    .T_W   (T_W),
    .PARTS (PARTS),
    .BITS  (DATA_W)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_q.vld),
    .first_i (s1_q.first),
    .last_i  (s1_q.last),
    .parts_i (parts_flat),
    .sum_o   (acc_s),
    .carry_o (acc_c),
    .done_o  (acc_done)
  );

  // result is held in doubled units, so one right shift is exact
  assign full_sum = acc_s + acc_c + CORR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= acc_done;
      if (acc_done) result_o <= full_sum[OUT_W:1];
    end
  end

  assert_exact_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done |-> (full_sum[0] == 1'b0));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done |-> ((&full_sum[ACC_W-1:OUT_W]) || !(|full_sum[ACC_W-1:OUT_W])));

  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (!out_valid_o && result_o == '0);
  end

  logic            lat_run_q;
  logic [LC_W-1:0] lat_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_run_q <= 1'b0;
      lat_cnt_q <= '0;
    end else if (accept) begin
      lat_run_q <= 1'b1;
      lat_cnt_q <= '0;
    end else if (out_valid_o) begin
      lat_run_q <= 1'b0;
    end else if (lat_run_q) begin
      lat_cnt_q <= lat_cnt_q + 1'b1;
    end
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (lat_run_q && lat_cnt_q == LC_W'(LAT)));

  assert_accept_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (!lat_run_q || out_valid_o));

endmodule

// File: tb/tb_da_obc_fir.sv
module tb_da_obc_fir;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic signed [7:0] sample_i = '0;
  logic              out_valid_o;
  logic signed [17:0] result_o;

  da_obc_fir dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .sample_i    (sample_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o)
  );

  always #4 clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int hist [4] = '{0, 0, 0, 0};
  int coef [4] = '{7, -45, 127, -128};
  int    exp_val [$];
  int    exp_cyc [$];
  string exp_req [$];
  bit done = 0;

  always @(posedge clk_i) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic model_push(input int x, input string req);
    int y;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    y = 0;
    for (int k = 0; k < 4; k++) y += coef[k] * hist[k];
    exp_val.push_back(y);
    exp_cyc.push_back(cyc + 11);
    exp_req.push_back(req);
  endtask

  // all driver tasks start and end on a falling edge
  task automatic send(input int x, input string req);
    sample_i = 8'(x);
    in_valid_i = 1'b1;
    model_push(x, req);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
  endtask

  task automatic send_junk(input int x, input int junk, input int off);
    sample_i = 8'(x);
    in_valid_i = 1'b1;
    model_push(x, "R4");
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (off - 1) @(negedge clk_i);
    sample_i = 8'(junk);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (10 - off) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    exp_val.delete();
    exp_cyc.delete();
    exp_req.delete();
    for (int k = 0; k < 4; k++) hist[k] = 0;
    repeat (2) @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
    check(result_o == '0, "R1", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // scoreboard monitor
  bit prev_ov  = 0;
  int prev_res = 0;
  int last_res = 0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_ov  = 0;
      last_res = 0;
      prev_res = 0;
    end else begin
      if (out_valid_o) begin
        if (prev_ov) check(1'b0, "R3", 1, 0);
        else check(prev_res == last_res, "R7", prev_res, last_res);
        if (exp_val.size() == 0) begin
          check(1'b0, "R3", int'(result_o), 0);
        end else begin
          int v, c;
          string r;
          v = exp_val.pop_front();
          c = exp_cyc.pop_front();
          r = exp_req.pop_front();
          check(int'(result_o) == v, r, int'(result_o), v);
          check(cyc == c, "R3", cyc, c);
        end
        last_res = int'(result_o);
      end
      prev_ov  = out_valid_o;
      prev_res = int'(result_o);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3: actual watchdog expiry at cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
    check(result_o == '0, "R1", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8 impulse, first output also shows cleared taps (R1)
    send(1, "R8");
    for (int i = 0; i < 4; i++) send(0, "R8");

    // R4 junk on the first busy edge and on the last busy edge
    send_junk(50, -99, 1);
    send_junk(-3, 77, 10);
    send_junk(100, -128, 5);
    send(0, "R4");

    // R6 extremes
    for (int i = 0; i < 4; i++) send(-128, "R6");
    for (int i = 0; i < 4; i++) send(127, "R6");
    send(-128, "R6");
    send(127, "R6");
    send(-128, "R6");
    send(127, "R6");
    send(-128, "R6");

    // R5 held valid
    begin
      int vals [5] = '{-17, 88, -128, 127, 3};
      in_valid_i = 1'b1;
      for (int i = 0; i < 5; i++) begin
        sample_i = 8'(vals[i]);
        model_push(vals[i], "R5");
        repeat (11) @(negedge clk_i);
      end
      in_valid_i = 1'b0;
      @(negedge clk_i);
    end

    // R2 varied samples
    for (int i = 0; i < 24; i++) begin
      int x;
      x = int'($urandom_range(255)) - 128;
      send(x, "R2");
    end

    // R1 reset while busy cancels the pending sample and clears taps
    sample_i = 8'(9);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    do_reset();
    repeat (12) @(negedge clk_i);
    send(5, "R1");
    send(-2, "R1");

    repeat (15) @(negedge clk_i);
    check(exp_val.size() == 0, "R3", exp_val.size(), 0);
    done = 1;
    finish_run();
  end

endmodule